// File: doc/BRIEF.md
# CPU Reset Qualifier and Start-Vector Loader

This block sits between the board-level active-low reset input and a small CPU core. It accepts a reset only after the input has been sampled low on a minimum number of consecutive system clocks, so short glitches are filtered out. While the accepted reset is held, it forces the core's architectural reset values onto the core's state inputs: stack pointer, interrupt mask level, register-bank select, clock-gear divider and clock-multiplier enable. Outside reset, the values the core supplies pass through unchanged.

The internal reset drops in the same cycle that the input goes high. The block then reads the start vector, three bytes at consecutive addresses, over a byte-wide request/valid memory port. It assembles them into a 24-bit program counter and raises a run signal that lets the core begin instruction fetch. A new low level during the vector read aborts the read. The core then waits for a fully qualified reset.

The external input is treated as synchronous to the system clock. `arst_n` resets only this block's own state. After `arst_n` the core is held idle until a qualified external reset has been seen.

Top module: `cpu_reset_seq`

## Requirements
- R1: `cpu_reset_o` is high, combinationally, during the cycle after the QUAL_CLKS-th (default 20) consecutive rising edge at which `ext_reset_n` was sampled low. It stays high while the input remains low.
- R2: A low pulse sampled on fewer than QUAL_CLKS consecutive edges causes no reset. The low-cycle count clears on any edge at which the input is high, and a running core keeps `cpu_run_o` high.
- R3: `cpu_reset_o` falls in the same cycle that `ext_reset_n` goes high, with no stretch.
- R4: While `cpu_reset_o` is high, `sp_o` is 32'h00000000.
- R5: While `cpu_reset_o` is high, `imask_o` is 3'b111 (all levels up to 7 masked) and `bank_o` is 2'b00 (bank 0).
- R6: While `cpu_reset_o` is high, `gear_o` carries code 3'd4, which means divide-by-16 (codes 0 to 4 mean divide-by 1, 2, 4, 8, 16), and `pll_en_o` is 0.
- R7: While `cpu_reset_o` is low, `sp_o`, `imask_o`, `bank_o`, `gear_o` and `pll_en_o` equal `sp_i`, `imask_i`, `bank_i`, `gear_i` and `pll_en_i`.
- R8: After release, the block reads addresses 24'hFFFF00, 24'hFFFF01 and 24'hFFFF02 in that order. Each read is a one-cycle `mem_req_o` pulse followed by a wait for `mem_valid_i`, and a new request is issued only after the previous byte has been taken.
- R9: The program counter on `pc_o` takes bits 7:0 from 24'hFFFF00, bits 15:8 from 24'hFFFF01 and bits 23:16 from 24'hFFFF02.
- R10: `cpu_run_o` rises in the cycle after the third byte is taken. It is never high while `cpu_reset_o` is high.
- R11: A low level on `ext_reset_n` during the vector read aborts it. No run and no further request follow until a newly qualified reset has been released, and that reset restarts the whole sequence.
- R12: After `arst_n`, `cpu_run_o` and `mem_req_o` stay low until a qualified reset has been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset of this block |
| ext_reset_n | input | 1 | External active-low reset request, synchronous to clk |
| sp_i | input | 32 | Stack pointer from the core |
| imask_i | input | 3 | Interrupt mask level from the core |
| bank_i | input | 2 | Register-bank select from the core |
| gear_i | input | 3 | Clock-gear code from the core |
| pll_en_i | input | 1 | Clock-multiplier enable from the core |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data byte |
| cpu_reset_o | output | 1 | Qualified internal reset |
| sp_o | output | 32 | Stack pointer to the core |
| imask_o | output | 3 | Interrupt mask level to the core |
| bank_o | output | 2 | Register-bank select to the core |
| gear_o | output | 3 | Clock-gear code to the core |
| pll_en_o | output | 1 | Clock-multiplier enable to the core |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 24 | Read byte address |
| pc_o | output | 24 | Assembled start program counter |
| cpu_run_o | output | 1 | Instruction fetch may begin |

## Verification
A low-cycle count that is off by one shows up at `cpu_reset_o` in the very cycle a 19- or 20-edge pulse ends. A stuck sequencer state shows up within one cycle as a request pulse that is missing, doubled or misaddressed, or as `cpu_run_o` rising early or not at all. A byte placed in the wrong lane becomes visible on `pc_o` in the first running cycle. Memory latencies of zero and several cycles, aborts in mid-read and pulses on both sides of the threshold are compared against a behavioural model on every clock.

// File: rtl/cpu_reset_pkg.sv
package cpu_reset_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_HELD = 3'd1,
    SQ_REQ  = 3'd2,
    SQ_WAIT = 3'd3,
    SQ_RUN  = 3'd4
  } seq_state_t;

  localparam int          GEAR_W     = 3;
  localparam logic [2:0]  GEAR_DIV16 = 3'd4;

endpackage

// File: rtl/rst_qualify.sv
module rst_qualify #(
  parameter int QUAL_CLKS = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic ext_reset_n,
  output logic accept_next_o,
  output logic cpu_reset_o
);
  localparam int CNT_W = $clog2(QUAL_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CLKS);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(QUAL_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sat;

  assign sat = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (ext_reset_n)  cnt_d = '0;
    else if (!sat)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign accept_next_o = !ext_reset_n && (cnt_q >= CNT_PRE);
  assign cpu_reset_o   = sat && !ext_reset_n;

  // R1: saturation is reached only from the threshold-minus-one count while low
  a_r1_accept_count: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sat) |-> ($past(cnt_q) == CNT_PRE) && !$past(ext_reset_n));

  // R2: a high sample clears the low-cycle count
  a_r2_count_clear: assert property (@(posedge clk) disable iff (!arst_n)
    ext_reset_n |=> (cnt_q == '0));

endmodule

// File: rtl/vec_fetch.sv
module vec_fetch
  import cpu_reset_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          VEC_BYTES = 3,
  parameter logic [23:0] VEC_BASE  = 24'hFFFF00
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   ext_reset_n,
  input  logic                   accept_next_i,
  input  logic                   mem_valid_i,
  input  logic [7:0]             mem_data_i,
  output logic                   mem_req_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [8*VEC_BYTES-1:0] pc_o,
  output seq_state_t             state_o
);
  localparam int IDX_W = (VEC_BYTES > 1) ? $clog2(VEC_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(VEC_BYTES - 1);

  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             take;

  assign take = (st_q == SQ_WAIT) && ext_reset_n && mem_valid_i;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (accept_next_i) begin
      st_d  = SQ_HELD;
      idx_d = '0;
    end else begin
      unique case (st_q)
        SQ_HELD: if (ext_reset_n) begin
          st_d  = SQ_REQ;
          idx_d = '0;
        end
        SQ_REQ:  st_d = ext_reset_n ? SQ_WAIT : SQ_IDLE;
        SQ_WAIT: begin
          if (!ext_reset_n) st_d = SQ_IDLE;
          else if (mem_valid_i) begin
            if (idx_q == IDX_LAST) st_d = SQ_RUN;
            else begin
              st_d  = SQ_REQ;
              idx_d = idx_q + 1'b1;
            end
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                            pc_o[g*8 +: 8] <= '0;
      else if (take && idx_q == IDX_W'(g))    pc_o[g*8 +: 8] <= mem_data_i;
    end
  end

  assign mem_req_o  = (st_q == SQ_REQ);
  assign mem_addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(idx_q);
  assign state_o    = st_q;

  // R8: every request is a single-cycle pulse
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!arst_n)
    mem_req_o |=> !mem_req_o);

  // R8: requests stay inside the vector window
  a_r8_addr_window: assert property (@(posedge clk) disable iff (!arst_n)
    mem_req_o |-> (mem_addr_o >= ADDR_W'(VEC_BASE)) &&
                  (mem_addr_o <  ADDR_W'(VEC_BASE) + ADDR_W'(VEC_BYTES)));

  // R3: release moves straight to the first request
  a_r3_release_fetch: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == SQ_HELD) && ext_reset_n |=> (st_q == SQ_REQ));

  // R11: a low level mid-read that is not yet qualified parks the sequencer
  a_r11_abort: assert property (@(posedge clk) disable iff (!arst_n)
    ((st_q == SQ_REQ) || (st_q == SQ_WAIT)) && !ext_reset_n && !accept_next_i
      |=> (st_q == SQ_IDLE));

endmodule

// File: rtl/arch_force.sv
module arch_force
  import cpu_reset_pkg::*;
#(
  parameter int SP_W    = 32,
  parameter int IMASK_W = 3,
  parameter int BANK_W  = 2
) (
  input  logic               force_i,
  input  logic [SP_W-1:0]    sp_i,
  input  logic [IMASK_W-1:0] imask_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [GEAR_W-1:0]  gear_i,
  input  logic               pll_en_i,
  output logic [SP_W-1:0]    sp_o,
  output logic [IMASK_W-1:0] imask_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [GEAR_W-1:0]  gear_o,
  output logic               pll_en_o
);
  always_comb begin
    if (force_i) begin
      sp_o     = '0;
      imask_o  = '1;
      bank_o   = '0;
      gear_o   = GEAR_DIV16;
      pll_en_o = 1'b0;
    end else begin
      sp_o     = sp_i;
      imask_o  = imask_i;
      bank_o   = bank_i;
      gear_o   = gear_i;
      pll_en_o = pll_en_i;
    end
  end
endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
  import cpu_reset_pkg::*;
#(
  parameter int          QUAL_CLKS = 20,
  parameter int          SP_W      = 32,
  parameter int          IMASK_W   = 3,
  parameter int          BANK_W    = 2,
  parameter int          ADDR_W    = 24,
  parameter int          VEC_BYTES = 3,
  parameter logic [23:0] VEC_BASE  = 24'hFFFF00
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   ext_reset_n,
  input  logic [SP_W-1:0]        sp_i,
  input  logic [IMASK_W-1:0]     imask_i,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic [GEAR_W-1:0]      gear_i,
  input  logic                   pll_en_i,
  input  logic                   mem_valid_i,
  input  logic [7:0]             mem_data_i,
  output logic                   cpu_reset_o,
  output logic [SP_W-1:0]        sp_o,
  output logic [IMASK_W-1:0]     imask_o,
  output logic [BANK_W-1:0]      bank_o,
  output logic [GEAR_W-1:0]      gear_o,
  output logic                   pll_en_o,
  output logic                   mem_req_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [8*VEC_BYTES-1:0] pc_o,
  output logic                   cpu_run_o
);
  logic       accept_next;
  seq_state_t seq_st;

  rst_qualify #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk          (clk),
    .arst_n       (arst_n),
    .ext_reset_n  (ext_reset_n),
    .accept_next_o(accept_next),
    .cpu_reset_o  (cpu_reset_o)
  );

  vec_fetch #(
    .ADDR_W   (ADDR_W),
    .VEC_BYTES(VEC_BYTES),
    .VEC_BASE (VEC_BASE)
  ) u_fetch (
    .clk          (clk),
    .arst_n       (arst_n),
    .ext_reset_n  (ext_reset_n),
    .accept_next_i(accept_next),
    .mem_valid_i  (mem_valid_i),
    .mem_data_i   (mem_data_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .pc_o         (pc_o),
    .state_o      (seq_st)
  );

  arch_force #(
    .SP_W   (SP_W),
    .IMASK_W(IMASK_W),
    .BANK_W (BANK_W)
  ) u_force (
    .force_i (cpu_reset_o),
    .sp_i    (sp_i),
    .imask_i (imask_i),
    .bank_i  (bank_i),
    .gear_i  (gear_i),
    .pll_en_i(pll_en_i),
    .sp_o    (sp_o),
    .imask_o (imask_o),
    .bank_o  (bank_o),
    .gear_o  (gear_o),
    .pll_en_o(pll_en_o)
  );

  assign cpu_run_o = (seq_st == SQ_RUN);

  // R10: the core never runs while the qualified reset is held
  a_r10_run_vs_reset: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_run_o |-> !cpu_reset_o);

  // R10: run rises only out of the final byte wait
  a_r10_run_entry: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(cpu_run_o) |-> $past(seq_st) == SQ_WAIT && $past(mem_valid_i));

  // R4, R5: stack pointer, mask and bank carry their reset values
  a_r5_forced_regs: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_reset_o |-> (sp_o == '0) && (&imask_o) && (bank_o == '0));

  // R6: slowest gear and multiplier bypassed during reset
  a_r6_clock_safe: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_reset_o |-> (gear_o == GEAR_DIV16) && !pll_en_o);

  // R12: no request without a preceding held reset
  a_r12_req_origin: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(mem_req_o) |-> $past(seq_st) inside {SQ_HELD, SQ_WAIT});

endmodule

// File: tb/test_cpu_reset_seq.sv
module test_cpu_reset_seq;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        ext_n = 1'b1;
  logic [31:0] sp_i = 32'h1234_5678;
  logic [2:0]  imask_i = 3'd2;
  logic [1:0]  bank_i = 2'd3;
  logic [2:0]  gear_i = 3'd1;
  logic        pll_i = 1'b1;
  logic        mem_valid = 1'b0;
  logic [7:0]  mem_data = 8'h00;
  logic        cpu_reset_o, pll_en_o, mem_req_o, cpu_run_o;
  logic [31:0] sp_o;
  logic [2:0]  imask_o, gear_o;
  logic [1:0]  bank_o;
  logic [23:0] mem_addr_o, pc_o;

  always #5 clk = ~clk;

  cpu_reset_seq i_cpu_reset_seq (
    .clk(clk), .arst_n(arst_n), .ext_reset_n(ext_n),
    .sp_i(sp_i), .imask_i(imask_i), .bank_i(bank_i), .gear_i(gear_i),
    .pll_en_i(pll_i), .mem_valid_i(mem_valid), .mem_data_i(mem_data),
    .cpu_reset_o(cpu_reset_o), .sp_o(sp_o), .imask_o(imask_o),
    .bank_o(bank_o), .gear_o(gear_o), .pll_en_o(pll_en_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .pc_o(pc_o),
    .cpu_run_o(cpu_run_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // memory responder
  logic [7:0] vec [3];
  int  lat = 0;
  bit  pend = 1'b0;
  int  wcnt = 0;
  int  ridx = 0;
  initial forever begin
    @(negedge clk); #2;
    mem_valid = 1'b0;
    if (pend) begin
      if (wcnt == 0) begin
        mem_valid = 1'b1;
        mem_data  = vec[ridx];
        pend      = 1'b0;
      end else wcnt--;
    end
    if (mem_req_o) begin
      pend = 1'b1;
      wcnt = lat;
      ridx = int'(mem_addr_o - 24'hFFFF00);
    end
  end

  // behavioural reference: 0 idle, 1 held, 2 request, 3 waiting, 4 running
  int          m_low = 0;
  int          m_st  = 0;
  int          m_idx = 0;
  logic [23:0] m_pc  = '0;
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_low = 0; m_st = 0; m_idx = 0; m_pc = '0;
    end else begin
      if (!ext_n && m_low >= 19) begin
        m_st = 1; m_idx = 0;
      end else if (m_st == 1 && ext_n) begin
        m_st = 2; m_idx = 0;
      end else if (m_st == 2) begin
        m_st = ext_n ? 3 : 0;
      end else if (m_st == 3) begin
        if (!ext_n) m_st = 0;
        else if (mem_valid) begin
          m_pc[m_idx*8 +: 8] = mem_data;
          if (m_idx == 2) m_st = 4;
          else begin m_idx++; m_st = 2; end
        end
      end
      if (ext_n) m_low = 0;
      else if (m_low < 20) m_low++;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (arst_n && !done) begin
      automatic bit e_rst = (m_low >= 20) && !ext_n;
      chk(cpu_reset_o == e_rst, "R1", 32'(cpu_reset_o), 32'(e_rst));
      chk(cpu_run_o == (m_st == 4), "R10", 32'(cpu_run_o), 32'(m_st == 4));
      chk(mem_req_o == (m_st == 2), "R8", 32'(mem_req_o), 32'(m_st == 2));
      if (m_st == 2)
        chk(mem_addr_o == 24'hFFFF00 + 24'(m_idx), "R8", 32'(mem_addr_o),
            32'(24'hFFFF00 + 24'(m_idx)));
      if (m_st == 4) chk(pc_o == m_pc, "R9", 32'(pc_o), 32'(m_pc));
      if (e_rst) begin
        chk(sp_o == 32'h0, "R4", sp_o, 32'h0);
        chk({imask_o, bank_o} == 5'b11100, "R5", 32'({imask_o, bank_o}), 32'b11100);
        chk({gear_o, pll_en_o} == 4'b1000, "R6", 32'({gear_o, pll_en_o}), 32'b1000);
      end else begin
        chk(sp_o == sp_i, "R7", sp_o, sp_i);
        chk({imask_o, bank_o, gear_o, pll_en_o} == {imask_i, bank_i, gear_i, pll_i},
            "R7", 32'({imask_o, bank_o, gear_o, pll_en_o}),
            32'({imask_i, bank_i, gear_i, pll_i}));
      end
    end
  end

  // hold the input low for exactly n sampled edges, then release
  task automatic hold_low(input int n);
    @(negedge clk); #2;
    ext_n = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk); #1;
    if (n >= 20) chk(cpu_reset_o == 1'b1, "R1", 32'(cpu_reset_o), 32'd1);
    else         chk(cpu_reset_o == 1'b0, "R2", 32'(cpu_reset_o), 32'd0);
    #1;
    ext_n = 1'b1;
    #1;
    chk(cpu_reset_o == 1'b0, "R3", 32'(cpu_reset_o), 32'd0);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 arst_n = 1'b1;
    wait_cycles(10);
    chk(!cpu_run_o && !mem_req_o, "R12", 32'({cpu_run_o, mem_req_o}), 32'd0);

    // zero-latency vector read
    vec[0] = 8'h12; vec[1] = 8'h34; vec[2] = 8'h56; lat = 0;
    hold_low(20);
    wait_cycles(15);
    chk(pc_o == 24'h563412, "R9", 32'(pc_o), 32'h563412);
    chk(cpu_run_o == 1'b1, "R10", 32'(cpu_run_o), 32'd1);

    // glitch one edge short of the threshold while running
    hold_low(19);
    wait_cycles(3);
    chk(cpu_run_o == 1'b1, "R2", 32'(cpu_run_o), 32'd1);

    sp_i = 32'hCAFE_0010; imask_i = 3'd5; bank_i = 2'd1; gear_i = 3'd3; pll_i = 1'b0;
    wait_cycles(2);
    chk(sp_o == 32'hCAFE_0010, "R7", sp_o, 32'hCAFE_0010);

    // longer reset, slow memory
    vec[0] = 8'hAB; vec[1] = 8'hCD; vec[2] = 8'hEF; lat = 3;
    hold_low(30);
    wait_cycles(30);
    chk(pc_o == 24'hEFCDAB, "R9", 32'(pc_o), 32'hEFCDAB);

    // abort mid-read with a short pulse
    vec[0] = 8'h01; vec[1] = 8'h02; vec[2] = 8'h03;
    hold_low(20);
    wait_cycles(3);
    ext_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); #2;
    ext_n = 1'b1;
    wait_cycles(25);
    chk(!cpu_run_o && !mem_req_o, "R11", 32'({cpu_run_o, mem_req_o}), 32'd0);

    // recovery after a fresh qualified reset
    lat = 1;
    hold_low(22);
    wait_cycles(20);
    chk(pc_o == 24'h030201, "R11", 32'(pc_o), 32'h030201);
    chk(cpu_run_o == 1'b1, "R11", 32'(cpu_run_o), 32'd1);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule